// File: doc/BRIEF.md
# Interrupt Routing Matrix

This block sits between a large set of peripheral interrupt request lines and a parent interrupt controller that has far fewer inputs. It steers each of 128 request lines onto one of 24 output lines. Every request line owns a configuration word. The word holds an enable flag and the number of the output that the line should drive. Each output is the logical OR of all enabled lines whose configured number matches it. Many level-type sources can therefore share one output, while an edge-type source can keep an output to itself. Detecting edges, setting priority and vectoring are left to the parent controller.

Software reaches the block through a plain 32-bit register bus. Reads are combinational from the address. Writes take effect on the clock edge where the write enable is high. The request lines are asynchronous to the bus clock. Each one passes through a two-flop synchroniser, and both routing and readback use the synchronised value. A block of four read-only status words shows the synchronised state of all request lines, whatever their enables are set to. Software applies its own mask.

Top module: `irq_route_matrix`

## Requirements
- R1: The configuration word of request line n sits at byte address 4*n, for n from 0 to 127. Bit 31 is the enable flag and bits [4:0] hold the target output number. A read returns the value last written to those fields.
- R2: Reset clears every configuration word to zero, holds every output low and reads every status bit as zero.
- R3: Output o is high in exactly those cycles where at least one synchronised request line is high and that line is enabled with target number o.
- R4: Two or more enabled lines that name the same output are ORed together onto it.
- R5: Writing zero to a configuration word disables that line. From the next cycle it drives no output, even while it stays asserted.
- R6: A target number of 24 to 31 drives no output. The number is still stored and read back unchanged.
- R7: A change on a request line reaches the outputs and the status words after exactly two rising clock edges. After only one edge it is not yet visible.
- R8: The status word at byte address 0x420 + 4*k shows request line 32*k + b at bit b, for k from 0 to 3. The status bits ignore the enable flags.
- R9: A write to a status word, or to any address from 0x200 to 0x41F or from 0x430 up, changes no configuration. Reads of those unmapped addresses return zero.
- R10: Bits [30:5] of a configuration word always read as zero, whatever was written to them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and routing clock |
| rst_n | input | 1 | Active-low reset |
| irq_in | input | 128 | Asynchronous interrupt request lines |
| bus_addr | input | 12 | Byte address of the register access |
| bus_we | input | 1 | Write enable, sampled on the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| irq_out | output | 24 | Routed interrupt lines toward the parent controller |

## Verification
The hardest cases to reach from the ports are those where the configuration and the request pattern disagree: an output shared by several lines where only some are enabled, a line that is disabled or has an out-of-range target but is still asserted, and a status bit set on a disabled line. Directed sequences set up each of these on purpose. A seeded random phase then rewrites random configuration words with random enables and targets in the full 0 to 31 range, drives dense random request patterns and checks every output and status word against a model held in the bench.

// File: rtl/irqr_pkg.sv
package irqr_pkg;

  localparam int unsigned BUS_W = 32;

  // Build a readback word: enable flag on the top bit, target number in the
  // low idx_w bits, everything else zero.
  function automatic logic [BUS_W-1:0] cfg_pack(input logic en,
                                                input logic [7:0] idx,
                                                input int unsigned idx_w);
    logic [BUS_W-1:0] w;
    w = '0;
    w[BUS_W-1] = en;
    for (int j = 0; j < 8; j++) begin
      if (j < int'(idx_w)) w[j] = idx[j];
    end
    return w;
  endfunction

  // A line contributes to output o only when enabled and aimed at o.
  function automatic logic route_hit(input logic en, input logic req,
                                     input logic [7:0] idx,
                                     input logic [7:0] o);
    return en && req && (idx == o);
  endfunction

endpackage

// File: rtl/irqr_sync.sv
module irqr_sync #(
  parameter int unsigned W = 128
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/irqr_cfg_bank.sv
module irqr_cfg_bank #(
  parameter int unsigned N_IN  = 128,
  parameter int unsigned IDX_W = 5,
  parameter int unsigned WA    = 10
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wr_en,
  input  logic [WA-1:0]                   wr_word,
  input  logic [31:0]                     wr_data,
  output logic [N_IN-1:0]                 cfg_en,
  output logic [N_IN-1:0][IDX_W-1:0]      cfg_idx
);
  localparam int unsigned SEL_W = $clog2(N_IN);
  localparam logic [WA-1:0] N_IN_W = WA'(N_IN);

  logic             wr_hit;
  logic [SEL_W-1:0] sel;

  assign wr_hit = wr_en && (wr_word < N_IN_W);
  assign sel    = wr_word[SEL_W-1:0];

  for (genvar i = 0; i < N_IN; i++) begin : g_entry
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cfg_en[i]  <= 1'b0;
        cfg_idx[i] <= '0;
      end else if (wr_hit && sel == SEL_W'(i)) begin
        cfg_en[i]  <= wr_data[31];
        cfg_idx[i] <= wr_data[IDX_W-1:0];
      end
    end
  end

  // R9: configuration changes only through a decoded configuration write
  a_r9_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit |=> ($stable(cfg_en) && $stable(cfg_idx)));

  // R5: a zero word leaves the addressed line disabled
  a_r5_zero_disables: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && wr_data == 32'd0) |=> !cfg_en[$past(sel)]);
endmodule

// File: rtl/irqr_crossbar.sv
module irqr_crossbar
  import irqr_pkg::*;
#(
  parameter int unsigned N_IN  = 128,
  parameter int unsigned N_OUT = 24,
  parameter int unsigned IDX_W = 5
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [N_IN-1:0]             req,
  input  logic [N_IN-1:0]             cfg_en,
  input  logic [N_IN-1:0][IDX_W-1:0]  cfg_idx,
  output logic [N_OUT-1:0]            out
);
  for (genvar o = 0; o < N_OUT; o++) begin : g_out
    logic acc;
    always_comb begin
      acc = 1'b0;
      for (int i = 0; i < N_IN; i++) begin
        acc = acc | route_hit(cfg_en[i], req[i], 8'(cfg_idx[i]), 8'(o));
      end
    end
    assign out[o] = acc;
  end

  // R6: lines aimed past the last output never light one
  logic any_live_in_range;
  always_comb begin
    any_live_in_range = 1'b0;
    for (int i = 0; i < N_IN; i++) begin
      if (cfg_en[i] && req[i] && 32'(cfg_idx[i]) < N_OUT) any_live_in_range = 1'b1;
    end
  end
  a_r6_out_of_range_silent: assert property (@(posedge clk) disable iff (!rst_n)
    !any_live_in_range |-> (out == '0));
endmodule

// File: rtl/irq_route_matrix.sv
module irq_route_matrix
  import irqr_pkg::*;
#(
  parameter int unsigned N_IN        = 128,
  parameter int unsigned N_OUT       = 24,
  parameter int unsigned AW          = 12,
  parameter int unsigned STATUS_BASE = 32'h420
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_IN-1:0]   irq_in,
  input  logic [AW-1:0]     bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [N_OUT-1:0]  irq_out
);
  localparam int unsigned IDX_W     = $clog2(N_OUT);
  localparam int unsigned WA        = AW - 2;
  localparam int unsigned SEL_W     = $clog2(N_IN);
  localparam int unsigned N_STAT    = (N_IN + 31) / 32;
  localparam int unsigned STAT_WORD = STATUS_BASE / 4;

  logic [N_IN-1:0]            sync_q;
  logic [N_IN-1:0]            cfg_en;
  logic [N_IN-1:0][IDX_W-1:0] cfg_idx;
  logic [WA-1:0]              word;
  logic                       rd_cfg_hit;
  logic                       rd_stat_hit;
  logic [N_STAT*32-1:0]       stat_pad;

  assign word = bus_addr[AW-1:2];

  irqr_sync #(.W(N_IN)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(irq_in), .q(sync_q)
  );

  irqr_cfg_bank #(.N_IN(N_IN), .IDX_W(IDX_W), .WA(WA)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_we), .wr_word(word),
    .wr_data(bus_wdata), .cfg_en(cfg_en), .cfg_idx(cfg_idx)
  );

  irqr_crossbar #(.N_IN(N_IN), .N_OUT(N_OUT), .IDX_W(IDX_W)) u_xbar (
    .clk(clk), .rst_n(rst_n), .req(sync_q), .cfg_en(cfg_en),
    .cfg_idx(cfg_idx), .out(irq_out)
  );

  always_comb begin
    stat_pad = '0;
    stat_pad[N_IN-1:0] = sync_q;
  end

  always_comb begin
    rd_cfg_hit  = (word < WA'(N_IN));
    rd_stat_hit = 1'b0;
    bus_rdata   = '0;
    if (rd_cfg_hit) begin
      bus_rdata = cfg_pack(cfg_en[word[SEL_W-1:0]],
                           8'(cfg_idx[word[SEL_W-1:0]]), IDX_W);
    end else begin
      for (int k = 0; k < int'(N_STAT); k++) begin
        if (word == WA'(STAT_WORD + k)) begin
          rd_stat_hit = 1'b1;
          bus_rdata   = stat_pad[k*32 +: 32];
        end
      end
    end
  end

  // Cycles since reset, saturating, for the latency check
  logic [1:0] warm;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) warm <= '0;
    else if (warm != 2'd2) warm <= warm + 2'd1;
  end

  a_r3_quiet_inputs: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_q == '0) |-> (irq_out == '0));
  a_r5_all_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_en == '0) |-> (irq_out == '0));
  a_r10_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_cfg_hit |-> (bus_rdata[30:IDX_W] == '0));
  a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_cfg_hit && !rd_stat_hit) |-> (bus_rdata == '0));
  a_r7_two_edges: assert property (@(posedge clk) disable iff (!rst_n)
    (warm == 2'd2) |-> (sync_q == $past(irq_in, 2)));
endmodule

// File: tb/irq_route_matrix_test.sv
module irq_route_matrix_test;
  localparam int NI = 128;
  localparam int NO = 24;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NI-1:0] irq_in = '0;
  logic [11:0]   bus_addr = '0;
  logic          bus_we = 1'b0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [NO-1:0] irq_out;

  int vectors = 0;
  int errors  = 0;
  bit done    = 0;

  logic          m_en  [NI];
  logic [4:0]    m_idx [NI];
  logic [NI-1:0] m_in;

  always #2 clk = ~clk;

  irq_route_matrix uut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_addr(bus_addr),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_out(irq_out)
  );

  function automatic logic [NO-1:0] exp_out(input logic [NI-1:0] req);
    logic [NO-1:0] r = '0;
    for (int i = 0; i < NI; i++)
      if (m_en[i] && req[i] && m_idx[i] < NO) r[m_idx[i]] = 1'b1;
    return r;
  endfunction

  function automatic logic [31:0] exp_cfg(input int n);
    return {m_en[n], 26'd0, m_idx[n]};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
    if (a < 12'h200) begin
      m_en[a[8:2]]  = d[31];
      m_idx[a[8:2]] = d[4:0];
    end
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic drive(input logic [NI-1:0] v);
    @(negedge clk);
    irq_in = v; m_in = v;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic check_stat(input string req);
    logic [31:0] d;
    for (int k = 0; k < 4; k++) begin
      rd(12'h420 + 12'(4*k), d);
      check(req, d, m_in[k*32 +: 32]);
    end
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd20240607));
    for (int i = 0; i < NI; i++) begin m_en[i] = 0; m_idx[i] = 0; end
    m_in = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R2: reset state
    check("R2 out", 32'(irq_out), 32'd0);
    rd(12'h000, d); check("R2 cfg0", d, 32'd0);
    rd(12'h1FC, d); check("R2 cfg127", d, 32'd0);
    check_stat("R2 status");

    // R1, R3, R7: single route with latency
    wr(12'h014, 32'h8000_0003);
    rd(12'h014, d); check("R1 readback", d, 32'h8000_0003);
    @(negedge clk);
    irq_in[5] = 1'b1; m_in[5] = 1'b1;
    @(negedge clk);
    check("R7 one edge", 32'(irq_out), 32'd0);
    @(negedge clk);
    check("R7 two edges", 32'(irq_out), 32'h8);
    check("R3 single", 32'(irq_out), 32'(exp_out(m_in)));

    // R4: shared output 0
    wr(12'h190, 32'h8000_0000);
    wr(12'h01C, 32'h8000_0000);
    drive(m_in | (NI'(1) << 100));
    check("R4 shared one", 32'(irq_out), 32'h9);
    drive(m_in & ~(NI'(1) << 100) | (NI'(1) << 7));
    check("R4 shared other", 32'(irq_out), 32'h9);

    // R6: out-of-range target
    wr(12'h024, 32'h8000_0018);
    drive(m_in | (NI'(1) << 9));
    check("R6 no output", 32'(irq_out), 32'h9);
    rd(12'h024, d); check("R6 stored", d, 32'h8000_0018);

    // R5: zero write disables an asserted line
    wr(12'h014, 32'h0);
    check("R5 disabled", 32'(irq_out), 32'h1);

    // R10: reserved bits
    wr(12'h050, 32'hFFFF_FFFF);
    rd(12'h050, d); check("R10 reserved", d, 32'h8000_001F);

    // R8: status raw, independent of enables
    drive({32'hA5A5_0F0F, 32'h1234_5678, 32'h0, 32'hFFFF_0001});
    check_stat("R8 status");
    check("R3 pattern", 32'(irq_out), 32'(exp_out(m_in)));

    // R9: writes to status and unmapped space
    wr(12'h420, 32'hFFFF_FFFF);
    wr(12'h200, 32'hFFFF_FFFF);
    wr(12'h430, 32'hFFFF_FFFF);
    wr(12'hFFC, 32'hFFFF_FFFF);
    rd(12'h200, d); check("R9 unmapped 200", d, 32'd0);
    rd(12'h430, d); check("R9 unmapped 430", d, 32'd0);
    rd(12'h41C, d); check("R9 unmapped 41C", d, 32'd0);
    check_stat("R9 status unchanged");
    rd(12'h000, d); check("R9 cfg0 intact", d, exp_cfg(0));
    rd(12'h014, d); check("R9 cfg5 intact", d, exp_cfg(5));
    check("R9 out intact", 32'(irq_out), 32'(exp_out(m_in)));

    // Random phase
    for (int it = 0; it < 60; it++) begin
      for (int w = 0; w < 6; w++) begin
        int n = $urandom_range(0, NI-1);
        logic [31:0] v = $urandom;
        wr(12'(4*n), v);
        rd(12'(4*n), d); check("R1 random readback", d, exp_cfg(n));
      end
      drive({$urandom, $urandom, $urandom, $urandom});
      check("R3 random route", 32'(irq_out), 32'(exp_out(m_in)));
      check_stat("R8 random status");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule